// File: doc/BRIEF.md
# Grouped Interrupt Combiner

This block merges a wide set of level-sensitive interrupt lines into a smaller set of group requests for a parent interrupt controller. Each group takes eight input lines and produces one output, which is high while any of its enabled inputs is high. Groups are packed four to a 32-bit register bank, and each group uses one byte lane of its bank. With the default of 20 groups there are five banks.

Software controls enables per input through two write-only strobes per bank. One strobe register sets enable bits and the other clears them, so no read-modify-write is needed. A bank also has a read-only status register that shows which enabled inputs are active. The enable word can be read back, saved, and later restored with a clear-all write followed by a set write. Access is through a simple port with separate write and read strobes. Read data is registered.

Top module: `irq_group_combiner`

## Requirements
- R1: After reset every enable bit is 0, every `grp_irq` bit is 0 and `rd_data` is 0.
- R2: A write to offset 0x0 of bank b (address b*0x10) sets each enable bit whose `wr_data` bit is 1. Bits written 0 keep their value. Bit i of bank b's word belongs to input `irq_in[b*32+i]`.
- R3: A write to offset 0x4 of bank b clears each enable bit whose `wr_data` bit is 1. Bits written 0 keep their value.
- R4: A read of offset 0x0 of bank b returns that bank's 32 enable bits in input order.
- R5: A read of offset 0xC of bank b returns, for each bit, the AND of the input level and its enable bit.
- R6: `grp_irq[g]` is the OR of the status bits of byte lane g%4 of bank g/4, which are inputs g*8 to g*8+7. It follows input and enable changes without a register stage.
- R7: The following addresses are holes: offset 0x8, any bank index of 5 or more, and any address with bits [1:0] not zero. Writes to holes and to the status offset change nothing. Reads of holes and of offset 0x4 return 0.
- R8: After a write of 0xFFFFFFFF to a bank's clear offset and then a write of a saved word to its set offset, the enable word equals the saved word exactly.
- R9: `rd_data` takes the addressed value on the clock edge where `rd_en` is high, and is readable one cycle after the request. It holds its value while `rd_en` is low.
- R10: A read and a write in the same cycle are allowed. The read returns the state from before that cycle's write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | NUM_GROUPS*8 | Level-sensitive interrupt inputs |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Byte address of the read |
| rd_data | output | 32 | Registered read data |
| grp_irq | output | NUM_GROUPS | One combined request per group |

## Verification
The read path and the write path can act on the same bank in the same cycle. A read can sample the enable or status word on the same edge where a set or clear strobe changes it. The bench provokes this with directed set and clear writes issued together with reads of the same bank, and it also issues random overlapping reads and writes. A read issued this way must return the pre-write word, and the group outputs must show the post-write enables from the following cycle onward.

// File: rtl/irq_comb_pkg.sv
`timescale 1ns/1ps
package irq_comb_pkg;
    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_SET  = 2'd1,
        ACC_CLR  = 2'd2,
        ACC_STAT = 2'd3
    } reg_sel_e;

    localparam int BANK_STRIDE_LG2 = 4;
endpackage

// File: rtl/irq_comb_decode.sv
`timescale 1ns/1ps
module irq_comb_decode
    import irq_comb_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int NUM_BANKS = 5
) (
    input  logic                 req,
    input  logic [ADDR_W-1:0]    addr,
    output reg_sel_e             sel,
    output logic [NUM_BANKS-1:0] bank_hit
);
    localparam int BIDX_W = ADDR_W - BANK_STRIDE_LG2;

    logic [BIDX_W-1:0] bank_idx;
    logic              in_range;

    always_comb begin
        bank_idx = addr[ADDR_W-1:BANK_STRIDE_LG2];
        in_range = (32'(bank_idx) < 32'(NUM_BANKS));
        sel      = ACC_NONE;
        if (req && in_range && (addr[1:0] == 2'b00)) begin
            unique case (addr[3:2])
                2'd0:    sel = ACC_SET;
                2'd1:    sel = ACC_CLR;
                2'd3:    sel = ACC_STAT;
                default: sel = ACC_NONE;
            endcase
        end
        for (int b = 0; b < NUM_BANKS; b++) begin
            bank_hit[b] = (sel != ACC_NONE) && (bank_idx == BIDX_W'(b));
        end
    end
endmodule

// File: rtl/irq_comb_bank.sv
`timescale 1ns/1ps
module irq_comb_bank #(
    parameter int LANE_W     = 8,
    parameter int LANES      = 4,
    parameter int LANES_USED = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      set_hit,
    input  logic                      clr_hit,
    input  logic [LANE_W*LANES-1:0]   wr_data,
    input  logic [LANE_W*LANES-1:0]   irq_lvl,
    output logic [LANE_W*LANES-1:0]   en_q,
    output logic [LANE_W*LANES-1:0]   status,
    output logic [LANES-1:0]          lane_irq
);
    localparam int WORD_W = LANE_W * LANES;

    logic [WORD_W-1:0] vmask;
    logic [WORD_W-1:0] set_vec;
    logic [WORD_W-1:0] clr_vec;
    logic [WORD_W-1:0] en_d;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign vmask[l*LANE_W +: LANE_W] = (l < LANES_USED) ? {LANE_W{1'b1}} : {LANE_W{1'b0}};
        assign lane_irq[l]               = |status[l*LANE_W +: LANE_W];
    end

    always_comb begin
        set_vec = set_hit ? wr_data : '0;
        clr_vec = clr_hit ? wr_data : '0;
        en_d    = (en_q | set_vec) & ~clr_vec & vmask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    assign status = en_q & irq_lvl;
endmodule

// File: rtl/irq_comb_rdport.sv
`timescale 1ns/1ps
module irq_comb_rdport
    import irq_comb_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int NUM_BANKS = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rd_en,
    input  reg_sel_e                    sel,
    input  logic [NUM_BANKS-1:0]        bank_hit,
    input  logic [NUM_BANKS*WORD_W-1:0] en_flat,
    input  logic [NUM_BANKS*WORD_W-1:0] stat_flat,
    output logic [WORD_W-1:0]           rd_data
);
    logic [WORD_W-1:0] word;

    always_comb begin
        word = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_hit[b]) begin
                case (sel)
                    ACC_SET:  word = en_flat[b*WORD_W +: WORD_W];
                    ACC_STAT: word = stat_flat[b*WORD_W +: WORD_W];
                    default:  word = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= word;
    end
endmodule

// File: rtl/irq_group_combiner.sv
`timescale 1ns/1ps
module irq_group_combiner
    import irq_comb_pkg::*;
#(
    parameter int NUM_GROUPS = 20,
    parameter int LANE_W     = 8,
    parameter int LANES      = 4,
    parameter int ADDR_W     = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_GROUPS*LANE_W-1:0] irq_in,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [LANE_W*LANES-1:0]      wr_data,
    input  logic                         rd_en,
    input  logic [ADDR_W-1:0]            rd_addr,
    output logic [LANE_W*LANES-1:0]      rd_data,
    output logic [NUM_GROUPS-1:0]        grp_irq
);
    localparam int WORD_W    = LANE_W * LANES;
    localparam int NUM_BANKS = (NUM_GROUPS + LANES - 1) / LANES;
    localparam int TOT_W     = NUM_BANKS * WORD_W;

    reg_sel_e               wr_sel;
    reg_sel_e               rd_sel;
    logic [NUM_BANKS-1:0]   wr_hit;
    logic [NUM_BANKS-1:0]   rd_hit;
    logic [TOT_W-1:0]       irq_pad;
    logic [TOT_W-1:0]       en_flat;
    logic [TOT_W-1:0]       stat_flat;
    logic [NUM_BANKS*LANES-1:0] lane_all;

    assign irq_pad = TOT_W'(irq_in);

    irq_comb_decode #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS)) u_wr_dec (
        .req(wr_en), .addr(wr_addr), .sel(wr_sel), .bank_hit(wr_hit)
    );

    irq_comb_decode #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS)) u_rd_dec (
        .req(rd_en), .addr(rd_addr), .sel(rd_sel), .bank_hit(rd_hit)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int USED = ((NUM_GROUPS - b*LANES) >= LANES) ? LANES : (NUM_GROUPS - b*LANES);
        irq_comb_bank #(.LANE_W(LANE_W), .LANES(LANES), .LANES_USED(USED)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_hit  (wr_hit[b] && (wr_sel == ACC_SET)),
            .clr_hit  (wr_hit[b] && (wr_sel == ACC_CLR)),
            .wr_data  (wr_data),
            .irq_lvl  (irq_pad[b*WORD_W +: WORD_W]),
            .en_q     (en_flat[b*WORD_W +: WORD_W]),
            .status   (stat_flat[b*WORD_W +: WORD_W]),
            .lane_irq (lane_all[b*LANES +: LANES])
        );
    end

    irq_comb_rdport #(.WORD_W(WORD_W), .NUM_BANKS(NUM_BANKS)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .sel(rd_sel), .bank_hit(rd_hit),
        .en_flat(en_flat), .stat_flat(stat_flat), .rd_data(rd_data)
    );

    assign grp_irq = lane_all[NUM_GROUPS-1:0];
endmodule

// File: rtl/irq_group_combiner_chk.sv
`timescale 1ns/1ps
module irq_group_combiner_chk #(
    parameter int NUM_GROUPS = 20,
    parameter int LANE_W     = 8,
    parameter int LANES      = 4,
    parameter int ADDR_W     = 8,
    parameter int NUM_BANKS  = 5
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          wr_en,
    input logic [ADDR_W-1:0]             wr_addr,
    input logic [LANE_W*LANES-1:0]       wr_data,
    input logic                          rd_en,
    input logic [LANE_W*LANES-1:0]       rd_data,
    input logic [NUM_GROUPS*LANE_W-1:0]  irq_in,
    input logic [NUM_GROUPS-1:0]         grp_irq,
    input logic [NUM_BANKS*LANE_W*LANES-1:0] en_flat
);
    localparam int W = LANE_W * LANES;

    AST_IDLE_EN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(en_flat)); // R2

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data)); // R9

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_b
        localparam int USED = ((NUM_GROUPS - b*LANES) >= LANES) ? LANES : (NUM_GROUPS - b*LANES);
        logic [W-1:0] vm;
        for (genvar l = 0; l < LANES; l++) begin : g_l
            assign vm[l*LANE_W +: LANE_W] = (l < USED) ? {LANE_W{1'b1}} : {LANE_W{1'b0}};
        end

        AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == ADDR_W'(b*16)) |=>
            ((en_flat[b*W +: W] & $past(wr_data)) == ($past(wr_data) & vm))); // R2

        AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == ADDR_W'(b*16 + 4)) |=>
            ((en_flat[b*W +: W] & $past(wr_data)) == '0)); // R3

        AST_HOLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == ADDR_W'(b*16 + 8)) |=> $stable(en_flat)); // R7
    end

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_g
        AST_OUT_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
            grp_irq[g] |-> ((|en_flat[g*LANE_W +: LANE_W]) && (|irq_in[g*LANE_W +: LANE_W]))); // R6
    end
endmodule

bind irq_group_combiner irq_group_combiner_chk #(
    .NUM_GROUPS(NUM_GROUPS), .LANE_W(LANE_W), .LANES(LANES),
    .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .irq_in(irq_in), .grp_irq(grp_irq), .en_flat(en_flat)
);

// File: tb/irq_group_combiner_bench.sv
`timescale 1ns/1ps
module irq_group_combiner_bench;
    localparam int NG = 20;
    localparam int NB = 5;
    localparam int IW = NG * 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [IW-1:0] irq_in = '0;
    logic          wr_en = 1'b0;
    logic [7:0]    wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic          rd_en = 1'b0;
    logic [7:0]    rd_addr = '0;
    logic [31:0]   rd_data;
    logic [NG-1:0] grp_irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [31:0] m_en [NB];
    logic [31:0] last_rd;

    always #2 clk = ~clk;

    irq_group_combiner u_irq_group_combiner (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .grp_irq(grp_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        int b = int'(a[7:4]);
        if (a[1:0] != 2'b00 || b >= NB) return 32'h0;
        case (a[3:2])
            2'd0:    return m_en[b];
            2'd3:    return m_en[b] & irq_in[b*32 +: 32];
            default: return 32'h0;
        endcase
    endfunction

    function automatic void m_write(input logic [7:0] a, input logic [31:0] d);
        int b = int'(a[7:4]);
        if (a[1:0] != 2'b00 || b >= NB) return;
        if (a[3:2] == 2'd0) m_en[b] = m_en[b] | d;
        else if (a[3:2] == 2'd1) m_en[b] = m_en[b] & ~d;
    endfunction

    function automatic logic [NG-1:0] exp_grp();
        logic [NG-1:0] r;
        for (int g = 0; g < NG; g++)
            r[g] = |(m_en[g/4][(g%4)*8 +: 8] & irq_in[g*8 +: 8]);
        return r;
    endfunction

    // one cycle: optional write and optional read driven together
    task automatic op(input bit dw, input logic [7:0] wa, input logic [31:0] wd,
                      input bit dr, input logic [7:0] ra, input string req);
        logic [31:0] er;
        @(negedge clk);
        wr_en = dw; wr_addr = wa; wr_data = wd;
        rd_en = dr; rd_addr = ra;
        er = exp_read(ra);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        if (dw) m_write(wa, wd);
        if (dr) begin
            chk(req, rd_data, er);
            last_rd = er;
        end
        chk({req, " R6 grp"}, 32'(grp_irq), 32'(exp_grp()));
    endtask

    task automatic rd(input logic [7:0] a, input string req);
        op(1'b0, 8'h0, 32'h0, 1'b1, a, req);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input string req);
        op(1'b1, a, d, 1'b0, 8'h0, req);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        int seed_dummy;
        logic [31:0] saved;
        seed_dummy = $urandom(32'h5EED);
        for (int b = 0; b < NB; b++) m_en[b] = '0;
        last_rd = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 rd_data", rd_data, 32'h0);
        chk("R1 grp_irq", 32'(grp_irq), 32'h0);
        rst_n = 1'b1;
        irq_in = '1;
        for (int b = 0; b < NB; b++) rd(8'(b*16), "R1 enables zero");
        irq_in = '0;

        // R2, R4 set and read back
        wr(8'h00, 32'h0000_00A5, "R2 set");
        rd(8'h00, "R2 R4 set A5");
        wr(8'h00, 32'h0000_0100, "R2 set more");
        rd(8'h00, "R2 zeros keep bits");
        // R3 clear
        wr(8'h04, 32'h0000_0001, "R3 clear");
        rd(8'h00, "R3 clear bit0");
        // R5, R6 status and group outputs
        wr(8'h30, 32'hFF00_0010, "R2 set bank3");
        irq_in = '0;
        irq_in[8] = 1'b1;       // group 1 input 0
        irq_in[96+4] = 1'b1;    // group 12
        irq_in[96+31] = 1'b1;   // group 15
        irq_in[96+30] = 1'b0;
        rd(8'h0C, "R5 status bank0");
        rd(8'h3C, "R5 status bank3");
        chk("R6 group 15", 32'(grp_irq[15]), 32'h1);
        chk("R6 group 12", 32'(grp_irq[12]), 32'h1);
        chk("R6 group 0", 32'(grp_irq[0]), 32'h0);
        // R7 holes
        wr(8'h08, 32'hFFFF_FFFF, "R7 hole 0x8");
        wr(8'h50, 32'hFFFF_FFFF, "R7 bank out of range");
        wr(8'h01, 32'hFFFF_FFFF, "R7 misaligned");
        wr(8'h0C, 32'hFFFF_FFFF, "R7 status write");
        for (int b = 0; b < NB; b++) rd(8'(b*16), "R7 enables unchanged");
        rd(8'h04, "R7 clear offset reads 0");
        rd(8'h18, "R7 hole read");
        rd(8'h50, "R7 out of range read");
        // R8 restore sequence
        wr(8'h20, 32'h5A3C_0F81, "R8 prep");
        rd(8'h20, "R8 save");
        saved = last_rd;
        wr(8'h20, 32'h0F0F_F0F0, "R8 scramble");
        wr(8'h24, 32'h8000_0001, "R8 scramble");
        wr(8'h24, 32'hFFFF_FFFF, "R8 clear all");
        wr(8'h20, saved, "R8 restore");
        rd(8'h20, "R8 restored");
        chk("R8 equals saved", last_rd, saved);
        // R9 hold while rd_en low
        rd(8'h00, "R9 read");
        wr(8'h00, 32'h00FF_0000, "R9 write between");
        chk("R9 rd_data held", rd_data, last_rd);
        // R10 same-cycle read and write, same bank
        op(1'b1, 8'h10, 32'h0000_FFFF, 1'b1, 8'h10, "R10 read before set");
        rd(8'h10, "R10 after set");
        op(1'b1, 8'h14, 32'h0000_00F0, 1'b1, 8'h10, "R10 read before clear");
        irq_in = '1;
        op(1'b1, 8'h14, 32'hFFFF_FFFF, 1'b1, 8'h1C, "R10 status before clear");
        // constrained random mix
        for (int i = 0; i < 400; i++) begin
            logic [7:0] wa, ra;
            logic [31:0] wd;
            if (($urandom % 4) == 0)
                for (int k = 0; k < IW / 32; k++) irq_in[k*32 +: 32] = $urandom & $urandom;
            wa = 8'((($urandom % 6) << 4) | (($urandom % 4) << 2));
            if (($urandom % 10) == 0) wa[0] = 1'b1;
            ra = 8'((($urandom % 6) << 4) | (($urandom % 4) << 2));
            wd = $urandom & $urandom;
            op(($urandom % 3) != 0, wa, wd, ($urandom % 2) == 0, ra, "R10 random mix");
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule